// File: doc/BRIEF.md
# Video Controller CPU Register Interface

This block is the processor-facing register file of a tile-based video controller. The processor reaches eight byte-wide registers through a 3-bit register select with separate read and write strobes. The block holds the control, mask and status registers, a 256-byte sprite attribute memory with its auto-incrementing pointer, and the scroll and address state. That state is a 15-bit current video address, a 15-bit temporary address, a 3-bit fine horizontal scroll and a first/second write toggle. The scroll and address registers share the toggle.

The renderer reads the control, mask, temporary address, current address and fine scroll from dedicated outputs. It reports vertical blank, sprite-zero hit and sprite overflow through one-cycle set pulses. A frame-clear pulse drops all three flags. Video-memory traffic goes through a simple port. Reads return data one cycle after the request. Video-data reads reach the processor through a one-deep buffer, so each read returns the byte fetched by the previous one.

Top module: `vid_cpu_regs`

## Requirements
- R1: After reset, control, mask, status, temporary address, current address, fine scroll, toggle and read buffer are all zero. Reads of selects 0 (control), 1 (mask), 3 (sprite pointer), 5 (scroll) and 6 (address) always return 0x00.
- R2: A status read (select 2) returns {vblank, hit, overflow, 5'b00000}, then clears vblank and puts the toggle in the first-write state. A vblank set pulse in the same cycle wins over the clear.
- R3: vblank_set, hit_set and ovf_set set status bits 7, 6 and 5. frame_clr clears all three and has priority over the set pulses.
- R4: A control write (select 0) stores the byte on ctrl_o and copies data bits 1:0 into temporary bits 11:10. Control bit 2 selects a video-address step of 32 when 1 and 1 when 0.
- R5: A mask write (select 1) stores the byte on mask_o.
- R6: A write to select 3 loads the 8-bit sprite pointer. Each read or write of select 4 accesses the 256-byte sprite memory at the pointer and then increments the pointer, wrapping from 255 to 0.
- R7: A first-state scroll write (select 5) puts data bits 7:3 into temporary bits 4:0 and data bits 2:0 into fine scroll.
- R8: A second-state scroll write puts data bits 2:0 into temporary bits 14:12 and data bits 7:3 into temporary bits 9:5.
- R9: A first-state address write (select 6) puts data bits 5:0 into temporary bits 13:8, clears temporary bit 14 and leaves bits 7:0 unchanged.
- R10: A second-state address write puts the byte into temporary bits 7:0 and loads the current address with the new temporary value, bit 14 forced to 0.
- R11: Every scroll or address write flips the single toggle that both registers share.
- R12: A data read (select 7) returns the buffered byte, requests video memory at the current address bits 13:0 and advances the current address by the step. The returned byte arrives one cycle later and refills the buffer. A data read in that next cycle returns the arriving byte.
- R13: A data write (select 7) writes the byte at current address bits 13:0 unless bit 13 is 0 and pattern_ro is 1. The current address advances by the step either way, modulo 2^15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Register read byte, valid in the strobe cycle |
| vblank_set | input | 1 | Sets the vertical-blank flag |
| hit_set | input | 1 | Sets the sprite-zero hit flag |
| ovf_set | input | 1 | Sets the sprite overflow flag |
| frame_clr | input | 1 | Clears all three status flags |
| pattern_ro | input | 1 | Pattern region (below 0x2000) is read-only |
| vm_addr | output | 14 | Video-memory address |
| vm_rd_en | output | 1 | Video-memory read request |
| vm_rd_data | input | 8 | Video-memory read byte, one cycle after request |
| vm_wr_en | output | 1 | Video-memory write enable |
| vm_wr_data | output | 8 | Video-memory write byte |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| tmp_addr_o | output | 15 | Temporary address |
| cur_addr_o | output | 15 | Current video address |
| fine_x_o | output | 3 | Fine horizontal scroll |

## Verification
A toggle left in the wrong state moves a scroll or address byte into the wrong temporary field. tmp_addr_o or fine_x_o shows this at the next clock edge. A stale or unforwarded read buffer appears as a repeated or lagging byte on rd_data on the very next data read. A wrong step or a missed advance shifts cur_addr_o at once and moves vm_addr for every later access. A broken pointer shows as a wrong sprite byte on the next sprite-data read.

// File: rtl/vid_regs_pkg.sv
package vid_regs_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_MASK = 3'd1,
    SEL_STAT = 3'd2,
    SEL_SPA  = 3'd3,
    SEL_SPD  = 3'd4,
    SEL_SCRL = 3'd5,
    SEL_ADDR = 3'd6,
    SEL_DATA = 3'd7
  } reg_sel_e;

  localparam int VA_W = 15;
  localparam int VM_W = 14;
  localparam int DW   = 8;
endpackage

// File: rtl/vid_scroll_addr.sv
module vid_scroll_addr
  import vid_regs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic            scr_wr,
  input  logic            adr_wr,
  input  logic            stat_rd,
  input  logic            adv,
  input  logic            inc32,
  input  logic [DW-1:0]   wdata,
  output logic [VA_W-1:0] tmp_q,
  output logic [VA_W-1:0] cur_q,
  output logic [2:0]      fx_q,
  output logic            toggle_q
);
  localparam logic [VA_W-1:0] STEP_LO = VA_W'(1);
  localparam logic [VA_W-1:0] STEP_HI = VA_W'(32);

  logic [VA_W-1:0] tmp_d, cur_d;
  logic [2:0]      fx_d;
  logic            toggle_d;
  logic            tmp_en, cur_en, fx_en, tog_en;

  always_comb begin
    tmp_d    = tmp_q;
    cur_d    = cur_q;
    fx_d     = fx_q;
    toggle_d = toggle_q;
    tmp_en   = ctl_wr | scr_wr | adr_wr;
    fx_en    = scr_wr & ~toggle_q;
    tog_en   = scr_wr | adr_wr | stat_rd;
    cur_en   = adv | (adr_wr & toggle_q);
    if (ctl_wr) tmp_d[11:10] = wdata[1:0];
    if (scr_wr) begin
      if (!toggle_q) begin
        tmp_d[4:0] = wdata[7:3];
        fx_d       = wdata[2:0];
      end else begin
        tmp_d[14:12] = wdata[2:0];
        tmp_d[9:5]   = wdata[7:3];
      end
      toggle_d = ~toggle_q;
    end
    if (adr_wr) begin
      if (!toggle_q) begin
        tmp_d[14]   = 1'b0;
        tmp_d[13:8] = wdata[5:0];
      end else begin
        tmp_d[7:0] = wdata;
        cur_d      = {1'b0, tmp_q[13:8], wdata};
      end
      toggle_d = ~toggle_q;
    end
    if (stat_rd) toggle_d = 1'b0;
    if (adv) cur_d = cur_q + (inc32 ? STEP_HI : STEP_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q    <= '0;
      cur_q    <= '0;
      fx_q     <= '0;
      toggle_q <= 1'b0;
    end else begin
      if (tmp_en) tmp_q    <= tmp_d;
      if (cur_en) cur_q    <= cur_d;
      if (fx_en)  fx_q     <= fx_d;
      if (tog_en) toggle_q <= toggle_d;
    end
  end

  // R10
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_wr && toggle_q) |=> (cur_q == {1'b0, tmp_q[13:0]}));
  // R2
  stat_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !toggle_q);
  // R11
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_wr || adr_wr) |=> (toggle_q != $past(toggle_q)));
  // R9
  t14_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_wr && !toggle_q) |=> !tmp_q[14]);
endmodule

// File: rtl/vid_sprite_ram.sv
module vid_sprite_ram
  import vid_regs_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = ptr_wr | acc_wr | acc_rd;
    ptr_d  = ptr_wr ? wdata[AW-1:0] : ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (acc_wr) mem[ptr_q] <= wdata;
  end

  assign rdata = mem[ptr_q];

  // R6
  spr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_wr || acc_rd) && !ptr_wr) |=> (ptr_q == $past(ptr_q) + AW'(1)));
endmodule

// File: rtl/vid_read_buf.sv
module vid_read_buf
  import vid_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [DW-1:0] mem_data,
  output logic [DW-1:0] buf_out
);
  logic          pend_q;
  logic [DW-1:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      pend_q <= req;
      if (pend_q) buf_q <= mem_data;
    end
  end

  assign buf_out = pend_q ? mem_data : buf_q;
endmodule

// File: rtl/vid_cpu_regs.sv
module vid_cpu_regs
  import vid_regs_pkg::*;
#(
  parameter int SPR_DEPTH = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      reg_sel,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic            vblank_set,
  input  logic            hit_set,
  input  logic            ovf_set,
  input  logic            frame_clr,
  input  logic            pattern_ro,
  output logic [VM_W-1:0] vm_addr,
  output logic            vm_rd_en,
  input  logic [DW-1:0]   vm_rd_data,
  output logic            vm_wr_en,
  output logic [DW-1:0]   vm_wr_data,
  output logic [DW-1:0]   ctrl_o,
  output logic [DW-1:0]   mask_o,
  output logic [VA_W-1:0] tmp_addr_o,
  output logic [VA_W-1:0] cur_addr_o,
  output logic [2:0]      fine_x_o
);
  reg_sel_e sel;
  logic     rd, wr;
  logic     stat_rd, data_rd, data_wr;
  logic     vb_q, hit_q, ovf_q, vb_d, hit_d, ovf_d;
  logic     flag_en;
  logic [DW-1:0] spr_rdata, buf_rdata;
  logic [VA_W-1:0] cur_q;
  logic     toggle_q;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr      = wr_en;
  assign rd      = rd_en & ~wr_en;
  assign stat_rd = rd & (sel == SEL_STAT);
  assign data_rd = rd & (sel == SEL_DATA);
  assign data_wr = wr & (sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      mask_o <= '0;
    end else begin
      if (wr && sel == SEL_CTRL) ctrl_o <= wr_data;
      if (wr && sel == SEL_MASK) mask_o <= wr_data;
    end
  end

  always_comb begin
    flag_en = frame_clr | vblank_set | hit_set | ovf_set | stat_rd;
    vb_d  = frame_clr ? 1'b0 : (vblank_set ? 1'b1 : (stat_rd ? 1'b0 : vb_q));
    hit_d = frame_clr ? 1'b0 : (hit_set | hit_q);
    ovf_d = frame_clr ? 1'b0 : (ovf_set | ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q  <= 1'b0;
      hit_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (flag_en) begin
      vb_q  <= vb_d;
      hit_q <= hit_d;
      ovf_q <= ovf_d;
    end
  end

  vid_scroll_addr u_sa (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (wr && sel == SEL_CTRL),
    .scr_wr   (wr && sel == SEL_SCRL),
    .adr_wr   (wr && sel == SEL_ADDR),
    .stat_rd  (stat_rd),
    .adv      (data_rd | data_wr),
    .inc32    (ctrl_o[2]),
    .wdata    (wr_data),
    .tmp_q    (tmp_addr_o),
    .cur_q    (cur_q),
    .fx_q     (fine_x_o),
    .toggle_q (toggle_q)
  );

  vid_sprite_ram #(.DEPTH(SPR_DEPTH)) u_spr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ptr_wr (wr && sel == SEL_SPA),
    .acc_wr (wr && sel == SEL_SPD),
    .acc_rd (rd && sel == SEL_SPD),
    .wdata  (wr_data),
    .rdata  (spr_rdata)
  );

  vid_read_buf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (data_rd),
    .mem_data (vm_rd_data),
    .buf_out  (buf_rdata)
  );

  assign cur_addr_o = cur_q;
  assign vm_addr    = cur_q[VM_W-1:0];
  assign vm_rd_en   = data_rd;
  assign vm_wr_en   = data_wr & ~(pattern_ro & ~cur_q[13]);
  assign vm_wr_data = wr_data;

  always_comb begin
    rd_data = '0;
    if (rd) begin
      case (sel)
        SEL_STAT: rd_data = {vb_q, hit_q, ovf_q, 5'b00000};
        SEL_SPD:  rd_data = spr_rdata;
        SEL_DATA: rd_data = buf_rdata;
        default:  rd_data = '0;
      endcase
    end
  end

  // R13
  pat_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vm_wr_en |-> !(pattern_ro && !vm_addr[13]));
  // R2
  vb_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !vblank_set) |=> !vb_q);
  // R3
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (!vb_q && !hit_q && !ovf_q));
  // R12
  rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vm_rd_en |=> (cur_q != $past(cur_q)));
endmodule

// File: tb/vid_cpu_regs_test.sv
module vid_cpu_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_sel;
  logic        rd_en, wr_en;
  logic [7:0]  wr_data, rd_data;
  logic        vblank_set, hit_set, ovf_set, frame_clr, pattern_ro;
  logic [13:0] vm_addr;
  logic        vm_rd_en, vm_wr_en;
  logic [7:0]  vm_rd_data, vm_wr_data;
  logic [7:0]  ctrl_o, mask_o;
  logic [14:0] tmp_addr_o, cur_addr_o;
  logic [2:0]  fine_x_o;

  int n_chk = 0;
  int n_bad = 0;
  int wcnt  = 0;
  logic [13:0] w_addr;
  logic [7:0]  w_data;

  always #10 clk = ~clk;

  vid_cpu_regs uut (.*);

  function automatic logic [7:0] vm_fn(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (vm_rd_en) vm_rd_data <= vm_fn(vm_addr);
    if (vm_wr_en) begin
      wcnt   <= wcnt + 1;
      w_addr <= vm_addr;
      w_data <= vm_wr_data;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    reg_sel = s; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    reg_sel = s; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 ctrl", 16'(ctrl_o), 16'h0);
    chk("R1 mask", 16'(mask_o), 16'h0);
    chk("R1 tmp", 16'(tmp_addr_o), 16'h0);
    chk("R1 cur", 16'(cur_addr_o), 16'h0);
    chk("R1 finex", 16'(fine_x_o), 16'h0);
    rd(3'd2, v); chk("R1 status", 16'(v), 16'h0);
  endtask

  task automatic t_data_read();
    logic [7:0] v;
    wr(3'd6, 8'h21); wr(3'd6, 8'h05);
    chk("R10 cur load", 16'(cur_addr_o), 16'h2105);
    rd(3'd7, v); chk("R12 first read buffer", 16'(v), 16'h00);
    rd(3'd7, v); chk("R12 back-to-back", 16'(v), 16'(vm_fn(14'h2105)));
    @(negedge clk);
    rd(3'd7, v); chk("R12 buffered", 16'(v), 16'(vm_fn(14'h2106)));
    chk("R12 advance", 16'(cur_addr_o), 16'h2108);
  endtask

  task automatic t_status();
    logic [7:0] v;
    vblank_set = 1'b1; hit_set = 1'b1; @(negedge clk);
    vblank_set = 1'b0; hit_set = 1'b0;
    rd(3'd2, v); chk("R2 status read", 16'(v), 16'hC0);
    rd(3'd2, v); chk("R2 vblank cleared", 16'(v), 16'h40);
    ovf_set = 1'b1; @(negedge clk); ovf_set = 1'b0;
    rd(3'd2, v); chk("R3 ovf set", 16'(v), 16'h60);
    frame_clr = 1'b1; vblank_set = 1'b1; @(negedge clk);
    frame_clr = 1'b0; vblank_set = 1'b0;
    rd(3'd2, v); chk("R3 frame clear", 16'(v), 16'h00);
    vblank_set = 1'b1;
    rd(3'd2, v);
    vblank_set = 1'b0;
    chk("R2 read with set", 16'(v), 16'h00);
    rd(3'd2, v); chk("R2 set wins", 16'(v), 16'h80);
  endtask

  task automatic t_ctrl_mask();
    logic [7:0] v;
    wr(3'd6, 8'h00); wr(3'd6, 8'h00);
    wr(3'd0, 8'h07);
    chk("R4 ctrl", 16'(ctrl_o), 16'h07);
    chk("R4 tmp nametable", 16'(tmp_addr_o), 16'h0C00);
    wr(3'd1, 8'h5C);
    chk("R5 mask", 16'(mask_o), 16'h5C);
    rd(3'd0, v); chk("R1 ctrl read zero", 16'(v), 16'h0);
    rd(3'd1, v); chk("R1 mask read zero", 16'(v), 16'h0);
    wr(3'd0, 8'h00);
    chk("R4 tmp nametable clr", 16'(tmp_addr_o), 16'h0000);
  endtask

  task automatic t_sprite();
    logic [7:0] v;
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'h11); wr(3'd4, 8'h22); wr(3'd4, 8'h33);
    wr(3'd3, 8'hFF);
    rd(3'd4, v); chk("R6 sprite at FF", 16'(v), 16'h22);
    rd(3'd4, v); chk("R6 sprite wrap", 16'(v), 16'h33);
    rd(3'd3, v); chk("R1 pointer read zero", 16'(v), 16'h0);
  endtask

  task automatic t_scroll();
    logic [7:0] v;
    rd(3'd2, v);
    wr(3'd5, 8'hAB);
    chk("R7 tmp", 16'(tmp_addr_o), 16'h0015);
    chk("R7 finex", 16'(fine_x_o), 16'h3);
    wr(3'd5, 8'h6E);
    chk("R8 tmp", 16'(tmp_addr_o), 16'h61B5);
    chk("R8 finex kept", 16'(fine_x_o), 16'h3);
    rd(3'd5, v); chk("R1 scroll read zero", 16'(v), 16'h0);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    logic [14:0] c0;
    c0 = cur_addr_o;
    rd(3'd2, v);
    wr(3'd6, 8'hFF);
    chk("R9 tmp", 16'(tmp_addr_o), 16'h3FB5);
    chk("R9 cur kept", 16'(cur_addr_o), 16'(c0));
    wr(3'd6, 8'h12);
    chk("R10 tmp", 16'(tmp_addr_o), 16'h3F12);
    chk("R10 cur", 16'(cur_addr_o), 16'h3F12);
    rd(3'd6, v); chk("R1 addr read zero", 16'(v), 16'h0);
  endtask

  task automatic t_toggle();
    logic [7:0] v;
    rd(3'd2, v);
    wr(3'd5, 8'hF9);
    chk("R11 scroll first", 16'(tmp_addr_o), 16'h3F1F);
    wr(3'd6, 8'h44);
    chk("R11 addr as second", 16'(cur_addr_o), 16'h3F44);
    wr(3'd5, 8'h08);
    chk("R11 scroll first again", 16'(fine_x_o), 16'h0);
    rd(3'd2, v);
    wr(3'd5, 8'h17);
    chk("R2 toggle reset tmp", 16'(tmp_addr_o), 16'h3F42);
    chk("R2 toggle reset finex", 16'(fine_x_o), 16'h7);
  endtask

  task automatic t_data_write();
    logic [7:0] v;
    int c0;
    rd(3'd2, v);
    pattern_ro = 1'b1;
    wr(3'd0, 8'h04);
    wr(3'd6, 8'h3F); wr(3'd6, 8'hE0);
    c0 = wcnt;
    wr(3'd7, 8'h99);
    chk("R13 write count", 16'(wcnt - c0), 16'd1);
    chk("R13 write addr", 16'(w_addr), 16'h3FE0);
    chk("R13 write data", 16'(w_data), 16'h99);
    chk("R4 step 32", 16'(cur_addr_o), 16'h4000);
    wr(3'd7, 8'h77);
    chk("R13 pattern blocked", 16'(wcnt - c0), 16'd1);
    chk("R13 advance when blocked", 16'(cur_addr_o), 16'h4020);
    pattern_ro = 1'b0;
    wr(3'd7, 8'h55);
    chk("R13 pattern writable", 16'(wcnt - c0), 16'd2);
    chk("R13 pattern addr", 16'(w_addr), 16'h0020);
    chk("R13 advance", 16'(cur_addr_o), 16'h4040);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    vblank_set = 1'b0; hit_set = 1'b0; ovf_set = 1'b0; frame_clr = 1'b0;
    pattern_ro = 1'b0; vm_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_read();
    t_status();
    t_ctrl_mask();
    t_sprite();
    t_scroll();
    t_addr();
    t_toggle();
    t_data_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule